// File: doc/BRIEF.md
# Leaf Page Permission Checker

This block decides whether a memory access may use a translation whose leaf page-table entry has already been fetched. It receives the 64-bit leaf entry, the kind of access (load, store or instruction fetch), whether the requester runs in user (problem) state, and the two-bit authority mask of the current context. From these it returns the read/write/execute rights the translation grants, a fault flag and a one-hot fault cause.

The rights come from a four-bit access-authority field in the entry: one privilege bit and three rights bits. A user access to a privileged page gets no rights. When exactly one of "user access" and "privileged page" holds, the entry's rights bits are used as they are. A supervisor access to a user page also passes through the context mask, which can remove read and write rights. Entries that carry the non-idempotent I/O attribute are treated as guarded, and any fetch from them fails before any rights are examined. The decision logic is combinational. A parameter selects an optional output register, which is on by default.

Top module: `leaf_perm_check`

## Requirements
- R1: When entry bits [5:4] equal 2'b10 (non-idempotent I/O) and the access code is fetch (2'b10), the block reports a fault with cause 3'b001 and grants no rights (grant 3'b000).
- R2: When the entry privilege bit [3] is 1 and user_i is 1, the granted rights are 3'b000.
- R3: When exactly one of user_i and entry bit [3] is 1, the granted rights equal entry bits [2:0]. Grant bit 2 is read, bit 1 is write and bit 0 is execute, in the same order as the entry bits.
- R4: When user_i is 0 and entry bit [3] is 0, the grant is entry bits [2:0] with read cleared if amask_i[0] is 1 and write cleared if amask_i[1] is 1. Execute is never masked.
- R5: Apart from R1, a fault is raised exactly when the right the access needs is absent from the grant. Load (2'b00) and the reserved code 2'b11 need read, store (2'b01) needs write, and fetch (2'b10) needs execute.
- R6: The cause is one-hot: 3'b010 for a protection fault on a load or fetch, 3'b100 for a protection fault on a store, 3'b001 for a guarded fetch, and 3'b000 with no fault. fault_o is 1 exactly when the cause is nonzero.
- R7: The I/O attribute has no effect on load and store accesses, and other attribute codes have no effect on fetches. Those accesses follow R2 to R5 only.
- R8: With the default REG_OUT=1, outputs appear one clock after the inputs are sampled. While rst_n is low at a rising edge, grant, fault and cause are cleared to zero.
- R9: Entry bits [63:6] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pte_i | input | 64 | Leaf page-table entry |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved (treated as load) |
| user_i | input | 1 | Access made in user (problem) state |
| amask_i | input | 2 | Context authority mask: bit 1 denies write, bit 0 denies read |
| grant_o | output | 3 | Granted rights {read, write, execute} |
| fault_o | output | 1 | Access is refused |
| cause_o | output | 3 | One-hot fault cause, zero without a fault |

## Verification
The bench targets a fetch from an I/O-attributed page that also has execute rights. A design that checks rights before the attribute would accept this fetch instead of reporting a guarded fault. It also pairs a supervisor access to a user page with each mask value. Swapping the mask bits, or letting the mask touch execute, would change which loads and stores fault. Store protection faults are checked for the store cause code, and random high entry bits must leave the result unchanged. A one-cycle latency check catches an output stage that is missing or doubled.

// File: rtl/leaf_perm_pkg.sv
// Shared encodings for the leaf permission checker.
package leaf_perm_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_t;

    localparam int RIGHTS_W = 3;
    localparam int RT_READ  = 2;
    localparam int RT_WRITE = 1;
    localparam int RT_EXEC  = 0;

    localparam int CAUSE_W = 3;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 3'b000;
    localparam logic [CAUSE_W-1:0] CAUSE_GUARD   = 3'b001;
    localparam logic [CAUSE_W-1:0] CAUSE_PROT_LD = 3'b010;
    localparam logic [CAUSE_W-1:0] CAUSE_PROT_ST = 3'b100;
endpackage

// File: rtl/authority_decode.sv
// Turns the access-authority field of a leaf entry into granted rights.
// Assumes: rights bits sit at [2:0] in {read,write,execute} order and the
// privilege bit is at PRIV_BIT; mask bit 1 denies write, bit 0 denies read.
module authority_decode
    import leaf_perm_pkg::*;
#(
    parameter int PRIV_BIT = 3
) (
    input  logic [PRIV_BIT:0]      auth_i,
    input  logic                   user_i,
    input  logic [1:0]             amask_i,
    output logic [RIGHTS_W-1:0]    grant_o
);
    logic [RIGHTS_W-1:0] keep;

    // Purpose: build the mask of rights the context mask leaves intact.
    always_comb begin
        keep           = '1;
        keep[RT_READ]  = ~amask_i[0];
        keep[RT_WRITE] = ~amask_i[1];
    end

    // Purpose: select the grant from privilege, user state and mask.
    always_comb begin
        if (auth_i[PRIV_BIT] && user_i) begin
            grant_o = '0;
        end else if (auth_i[PRIV_BIT] ^ user_i) begin
            grant_o = auth_i[RIGHTS_W-1:0];
        end else begin
            grant_o = auth_i[RIGHTS_W-1:0] & keep;
        end
    end
endmodule

// File: rtl/access_judge.sv
// Compares the granted rights with the access kind and the page attribute,
// producing the final grant, fault flag and one-hot cause.
// Assumes: the attribute field is two bits wide at ATT_LSB.
module access_judge
    import leaf_perm_pkg::*;
#(
    parameter logic [1:0] NIO_CODE = 2'b10
) (
    input  logic [1:0]             att_i,
    input  logic [1:0]             acc_i,
    input  logic [RIGHTS_W-1:0]    grant_i,
    output logic [RIGHTS_W-1:0]    grant_o,
    output logic                   fault_o,
    output logic [CAUSE_W-1:0]     cause_o
);
    acc_kind_t kind;
    logic      guarded;
    logic      needed;

    assign kind = acc_kind_t'(acc_i);

    // Purpose: find a fetch from a page carrying the I/O attribute.
    always_comb guarded = (kind == ACC_FETCH) && (att_i == NIO_CODE);

    // Purpose: pick the right the access kind requires.
    always_comb begin
        unique case (kind)
            ACC_STORE: needed = grant_i[RT_WRITE];
            ACC_FETCH: needed = grant_i[RT_EXEC];
            default:   needed = grant_i[RT_READ];
        endcase
    end

    // Purpose: rank the guarded fault over the protection fault.
    always_comb begin
        grant_o = grant_i;
        cause_o = CAUSE_NONE;
        if (guarded) begin
            grant_o = '0;
            cause_o = CAUSE_GUARD;
        end else if (!needed) begin
            cause_o = (kind == ACC_STORE) ? CAUSE_PROT_ST : CAUSE_PROT_LD;
        end
    end

    assign fault_o = |cause_o;
endmodule

// File: rtl/result_stage.sv
// Optional output register; a pass-through when REG_OUT is 0.
// Assumes a synchronous active-low reset clearing the stage to zero.
module result_stage #(
    parameter int W       = 7,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            // Purpose: hold the result for one cycle, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_o <= '0;
                else        q_o <= d_i;
            end
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/leaf_perm_check.sv
// Top of the leaf permission checker: decode rights, judge the access,
// optionally register the result. Assumes the entry is already fetched.
module leaf_perm_check
    import leaf_perm_pkg::*;
#(
    parameter int         ENTRY_W  = 64,
    parameter int         PRIV_BIT = 3,
    parameter int         ATT_LSB  = 4,
    parameter logic [1:0] NIO_CODE = 2'b10,
    parameter bit         REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRY_W-1:0]  pte_i,
    input  logic [1:0]          acc_i,
    input  logic                user_i,
    input  logic [1:0]          amask_i,
    output logic [RIGHTS_W-1:0] grant_o,
    output logic                fault_o,
    output logic [CAUSE_W-1:0]  cause_o
);
    localparam int USED_W = ATT_LSB + 2;
    localparam int RES_W  = RIGHTS_W + 1 + CAUSE_W;

    logic [RIGHTS_W-1:0] raw_grant;
    logic [RIGHTS_W-1:0] fin_grant;
    logic                fin_fault;
    logic [CAUSE_W-1:0]  fin_cause;
    logic                unused_hi;

    assign unused_hi = ^pte_i[ENTRY_W-1:USED_W];

    authority_decode #(.PRIV_BIT(PRIV_BIT)) u_auth (
        .auth_i  (pte_i[PRIV_BIT:0]),
        .user_i  (user_i),
        .amask_i (amask_i),
        .grant_o (raw_grant)
    );

    access_judge #(.NIO_CODE(NIO_CODE)) u_judge (
        .att_i   (pte_i[ATT_LSB+1:ATT_LSB]),
        .acc_i   (acc_i),
        .grant_i (raw_grant),
        .grant_o (fin_grant),
        .fault_o (fin_fault),
        .cause_o (fin_cause)
    );

    result_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({fin_grant, fin_fault, fin_cause}),
        .q_o   ({grant_o, fault_o, cause_o})
    );
endmodule

// File: rtl/leaf_perm_check_chk.sv
// Property checker for leaf_perm_check, attached by bind.
// Keeps its own copy of the inputs aligned to the output latency.
module leaf_perm_check_chk #(
    parameter int         ENTRY_W  = 64,
    parameter int         PRIV_BIT = 3,
    parameter int         ATT_LSB  = 4,
    parameter logic [1:0] NIO_CODE = 2'b10,
    parameter bit         REG_OUT  = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ENTRY_W-1:0] pte_i,
    input logic [1:0]         acc_i,
    input logic               user_i,
    input logic [2:0]         grant_o,
    input logic               fault_o,
    input logic [2:0]         cause_o
);
    logic [ENTRY_W-1:0] d_pte;
    logic [1:0]         d_acc;
    logic               d_user;
    logic               live;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                d_pte  <= pte_i;
                d_acc  <= acc_i;
                d_user <= user_i;
                if (!rst_n) live <= 1'b0;
                else        live <= 1'b1;
            end
        end else begin : g_now
            assign d_pte  = pte_i;
            assign d_acc  = acc_i;
            assign d_user = user_i;
            assign live   = 1'b1;
        end
    endgenerate

    // R1
    guard_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (d_acc == 2'b10 && d_pte[ATT_LSB+1:ATT_LSB] == NIO_CODE)
            |-> (cause_o == 3'b001 && grant_o == 3'b000));
    // R2
    priv_user_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (d_user && d_pte[PRIV_BIT]) |-> (grant_o == 3'b000));
    // R6
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));
    // R6
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == (cause_o != 3'b000));
    // R6
    store_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        cause_o[2] |-> (d_acc == 2'b01));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (grant_o == 3'b000 && !fault_o));
endmodule

bind leaf_perm_check leaf_perm_check_chk #(
    .ENTRY_W (ENTRY_W),
    .PRIV_BIT(PRIV_BIT),
    .ATT_LSB (ATT_LSB),
    .NIO_CODE(NIO_CODE),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pte_i   (pte_i),
    .acc_i   (acc_i),
    .user_i  (user_i),
    .grant_o (grant_o),
    .fault_o (fault_o),
    .cause_o (cause_o)
);

// File: tb/leaf_perm_check_test.sv
`timescale 1ns/1ps
module leaf_perm_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pte_i = '0;
    logic [1:0]  acc_i = '0;
    logic        user_i = 1'b0;
    logic [1:0]  amask_i = '0;
    logic [2:0]  grant_o;
    logic        fault_o;
    logic [2:0]  cause_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    leaf_perm_check uut (
        .clk(clk), .rst_n(rst_n), .pte_i(pte_i), .acc_i(acc_i),
        .user_i(user_i), .amask_i(amask_i),
        .grant_o(grant_o), .fault_o(fault_o), .cause_o(cause_o)
    );

    // Expected {grant, fault, cause} from the requirements.
    function automatic logic [6:0] model(input logic [63:0] e, input logic [1:0] a,
                                         input logic u, input logic [1:0] m);
        logic [2:0] g;
        logic [2:0] c;
        logic       need;
        if (a == 2'b10 && e[5:4] == 2'b10) return {3'b000, 1'b1, 3'b001};
        if (e[3] && u)       g = 3'b000;
        else if (e[3] ^ u)   g = e[2:0];
        else                 g = {e[2] & ~m[0], e[1] & ~m[1], e[0]};
        case (a)
            2'b01:   need = g[1];
            2'b10:   need = g[0];
            default: need = g[2];
        endcase
        c = need ? 3'b000 : ((a == 2'b01) ? 3'b100 : 3'b010);
        return {g, |c, c};
    endfunction

    function automatic string grant_tag(input logic [63:0] e, input logic [1:0] a,
                                        input logic u);
        if (a == 2'b10 && e[5:4] == 2'b10) return "R1";
        if (e[3] && u) return "R2";
        if (e[3] ^ u)  return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic apply(input logic [63:0] e, input logic [1:0] a, input logic u,
                         input logic [1:0] m, input string tag);
        logic [6:0] x;
        pte_i = e; acc_i = a; user_i = u; amask_i = m;
        x = model(e, a, u, m);
        @(negedge clk);
        check(tag.len() ? tag : grant_tag(e, a, u), grant_o, x[6:4], "grant");
        check("R5", fault_o, x[3], "fault");
        check("R6", cause_o, x[2:0], "cause");
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        // R8: reset clears outputs even with a faulting input
        pte_i = 64'h20; acc_i = 2'b10; user_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", {grant_o, fault_o, cause_o}, 0, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: I/O page with full rights still refuses a fetch
        apply(64'h27, 2'b10, 1'b0, 2'b00, "R1");
        apply(64'h2F, 2'b10, 1'b0, 2'b00, "R1");
        // R7: I/O attribute is inert for loads and stores; other codes for fetch
        apply(64'h27, 2'b00, 1'b0, 2'b00, "R7");
        apply(64'h27, 2'b01, 1'b0, 2'b00, "R7");
        apply(64'h11, 2'b10, 1'b0, 2'b00, "R7");
        apply(64'h30, 2'b10, 1'b0, 2'b00, "R7");
        // R2: privileged page, user access
        apply(64'h0F, 2'b00, 1'b1, 2'b00, "R2");
        // R3: direct rights
        apply(64'h0A, 2'b01, 1'b0, 2'b11, "R3");
        apply(64'h04, 2'b01, 1'b1, 2'b11, "R3");
        // R4: each mask value on a supervisor access to a user page
        for (int m = 0; m < 4; m++) begin
            apply(64'h07, 2'b00, 1'b0, m[1:0], "R4");
            apply(64'h07, 2'b01, 1'b0, m[1:0], "R4");
            apply(64'h07, 2'b10, 1'b0, m[1:0], "R4");
        end
        // R5: reserved code behaves as load
        apply(64'h03, 2'b11, 1'b1, 2'b00, "R5");
        apply(64'h04, 2'b11, 1'b1, 2'b00, "R5");
        // R9: high bits ignored
        for (int i = 0; i < 8; i++) begin
            logic [63:0] e;
            e = {$urandom, $urandom};
            e[5:0] = 6'h06;
            apply(e, 2'b01, 1'b1, 2'b01, "R9");
        end
        // R8: one-cycle latency, old result held until the next edge
        apply(64'h04, 2'b00, 1'b1, 2'b00, "R8");
        pte_i = 64'h00; acc_i = 2'b00; user_i = 1'b1;
        #1;
        check("R8", {grant_o, fault_o, cause_o}, 7'b100_0_000, "held before edge");
        @(negedge clk);
        check("R8", {grant_o, fault_o, cause_o}, 7'b000_1_010, "after edge");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] e;
            e = {$urandom, $urandom};
            apply(e, 2'($urandom), 1'($urandom), 2'($urandom), "");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule